// File: doc/BRIEF.md
# Single-Operand Accumulator Processor

This block is a small stored-program processor. Program words and data words sit in one memory, and both travel over a single address, write-data, read-data and write-enable port. The processor fetches one instruction word at the address in its program counter and latches it into an instruction register. It then advances the counter and carries out the instruction. Each instruction names one memory location. The accumulator is both the implicit second source and the destination.

Arithmetic results set a zero flag, and a conditional branch tests that flag. A halt instruction parks the processor until the next reset. The memory port expects a synchronous single-port memory: the word at the address presented in one cycle appears on the read-data input in the next cycle. A write takes effect at the clock edge that ends the cycle in which write-enable is high.

Top module: `acc_cpu`

## Requirements
- R1: While reset is low and in the first cycle after it is released, the processor presents address 0, keeps write-enable low and keeps the halted output low, so that execution begins at program counter 0.
- R2: Instructions and data share one memory through one port, so a word stored by the program and fetched later executes as an instruction.
- R3: An instruction is 16 bits wide. Bits [15:12] hold the opcode and bits [11:0] hold the operand address. The opcodes are LOAD=1, ADD=2, SUB=3, STORE=4, JMP=5, BEQ=6 and HALT=15.
- R4: LOAD sets the accumulator to the memory operand. ADD adds the operand to the accumulator, and SUB subtracts the operand from it, both modulo 2^16.
- R5: STORE writes the accumulator to the operand address with a write-enable pulse one cycle long. No other instruction writes memory.
- R6: The zero flag follows the accumulator result of LOAD, ADD and SUB only. BEQ loads the operand address into the program counter when the flag is set and otherwise falls through.
- R7: JMP always continues execution at the operand address.
- R8: After HALT the halted output stays high, write-enable stays low and the address stays still until reset.
- R9: An opcode outside the listed set changes neither the accumulator nor memory, and execution continues with the next word.
- R10: After a word is fetched, the program counter advances by one, so instructions run in address order unless a branch is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 12 | Address of the instruction or operand being accessed |
| mem_wdata | output | 16 | Accumulator value to be written |
| mem_we | output | 1 | Write strobe, high for one cycle per STORE |
| mem_rdata | input | 16 | Word read from memory, valid one cycle after its address |
| halted | output | 1 | High once a HALT has executed |

## Verification
The hardest case to reach from the ports is a program that rewrites its own instruction stream. The stored word has to reach memory before the fetch of that same location reads it. The stimulus produces this with a program that loads an encoded STORE word as data and writes it over a HALT that lies ahead in the program. The overwritten location then produces a second, predictable store instead of halting early.

A second program checks that the zero flag survives the instructions that must not touch it. It places a STORE between a SUB that produces zero and the BEQ that tests the flag. It also drives an ADD that wraps to zero, which shows the flag comes from the 16-bit result.

// File: rtl/acc_cpu_pkg.sv
// Package: shared widths, opcode codes and control-state type for the
// accumulator processor. Assumes a 16-bit word split as 4-bit opcode and
// 12-bit operand address (R3).
package acc_cpu_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 12;
    localparam int OP_W   = DATA_W - ADDR_W;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD  = 4'd1,
        OP_ADD   = 4'd2,
        OP_SUB   = 4'd3,
        OP_STORE = 4'd4,
        OP_JMP   = 4'd5,
        OP_BEQ   = 4'd6,
        OP_HALT  = 4'd15
    } opcode_t;

    typedef enum logic [2:0] {
        ST_FETCH  = 3'd0,
        ST_LATCH  = 3'd1,
        ST_DECODE = 3'd2,
        ST_EXEC   = 3'd3,
        ST_HALT   = 3'd4
    } state_t;
endpackage

// File: rtl/acc_cpu_alu.sv
// Module: combinational accumulator arithmetic. Picks the new accumulator
// value for LOAD, ADD and SUB; other opcodes pass the accumulator through.
// Assumes wrap-around arithmetic at DATA_W bits (R4).
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int W    = DATA_W,
    parameter int OPW  = OP_W
) (
    input  logic [OPW-1:0] op,
    input  logic [W-1:0]   acc,
    input  logic [W-1:0]   operand,
    output logic [W-1:0]   result
);
    // Select the arithmetic result for the decoded opcode.
    always_comb begin
        case (op)
            OP_LOAD: result = operand;
            OP_ADD:  result = acc + operand;
            OP_SUB:  result = acc - operand;
            default: result = acc;
        endcase
    end
endmodule

// File: rtl/acc_cpu_ctrl.sv
// Module: fetch/execute sequencer. Steps FETCH -> LATCH -> DECODE and,
// for instructions that read an operand, EXEC; parks in HALT.
// Assumes memory read data arrives one cycle after the address.
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
#(
    parameter int OPW = OP_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [OPW-1:0] opcode,
    input  logic           zero,
    output state_t         state,
    output logic           ir_ld,
    output logic           pc_inc,
    output logic           pc_ld,
    output logic           acc_ld,
    output logic           sel_operand,
    output logic           mem_we,
    output logic           halted
);
    state_t state_d;

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FETCH;
        else        state <= state_d;
    end

    // Next state and per-cycle control strobes.
    always_comb begin
        state_d     = state;
        ir_ld       = 1'b0;
        pc_inc      = 1'b0;
        pc_ld       = 1'b0;
        acc_ld      = 1'b0;
        sel_operand = 1'b0;
        mem_we      = 1'b0;
        case (state)
            ST_FETCH: state_d = ST_LATCH;
            ST_LATCH: begin
                ir_ld   = 1'b1;
                pc_inc  = 1'b1;
                state_d = ST_DECODE;
            end
            ST_DECODE: begin
                state_d = ST_FETCH;
                case (opcode)
                    OP_LOAD, OP_ADD, OP_SUB: begin
                        sel_operand = 1'b1;
                        state_d     = ST_EXEC;
                    end
                    OP_STORE: begin
                        sel_operand = 1'b1;
                        mem_we      = 1'b1;
                    end
                    OP_JMP:  pc_ld = 1'b1;
                    OP_BEQ:  pc_ld = zero;
                    OP_HALT: state_d = ST_HALT;
                    default: ;
                endcase
            end
            ST_EXEC: begin
                acc_ld  = 1'b1;
                state_d = ST_FETCH;
            end
            ST_HALT: state_d = ST_HALT;
            default: state_d = ST_FETCH;
        endcase
    end

    assign halted = (state == ST_HALT);
endmodule

// File: rtl/acc_cpu_dpath.sv
// Module: datapath holding program counter, instruction register,
// accumulator and zero flag, plus the memory address mux.
// Assumes control strobes from the sequencer are mutually consistent.
module acc_cpu_dpath
    import acc_cpu_pkg::*;
#(
    parameter int W   = DATA_W,
    parameter int AW  = ADDR_W,
    localparam int OPW = W - AW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ir_ld,
    input  logic           pc_inc,
    input  logic           pc_ld,
    input  logic           acc_ld,
    input  logic           sel_operand,
    input  logic [W-1:0]   rdata,
    input  logic [W-1:0]   alu_result,
    output logic [OPW-1:0] opcode,
    output logic [W-1:0]   acc,
    output logic           zero,
    output logic [AW-1:0]  addr
);
    logic [AW-1:0] pc;
    logic [W-1:0]  ir;
    logic [AW-1:0] operand_addr;

    assign opcode       = ir[W-1:AW];
    assign operand_addr = ir[AW-1:0];

    // Program counter: reset to 0, advance after fetch, load on branch.
    always_ff @(posedge clk) begin
        if (!rst_n)      pc <= '0;
        else if (pc_ld)  pc <= operand_addr;
        else if (pc_inc) pc <= pc + 1'b1;
    end

    // Instruction register captures the fetched word.
    always_ff @(posedge clk) begin
        if (!rst_n)     ir <= '0;
        else if (ir_ld) ir <= rdata;
    end

    // Accumulator and zero flag update together on arithmetic instructions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc  <= '0;
            zero <= 1'b0;
        end else if (acc_ld) begin
            acc  <= alu_result;
            zero <= (alu_result == '0);
        end
    end

    // Address mux: operand address during operand access, else the PC.
    always_comb addr = sel_operand ? operand_addr : pc;
endmodule

// File: rtl/acc_cpu.sv
// Module: top level of the accumulator processor. Connects sequencer,
// datapath and arithmetic unit to a synchronous single-port memory.
// Assumes read data is valid one cycle after the address is presented.
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int AW = ADDR_W,
    localparam int OPW = W - AW
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] mem_addr,
    output logic [W-1:0]  mem_wdata,
    output logic          mem_we,
    input  logic [W-1:0]  mem_rdata,
    output logic          halted
);
    state_t         state_q;
    logic [OPW-1:0] opcode;
    logic           zero_q;
    logic [W-1:0]   acc_q;
    logic [W-1:0]   alu_result;
    logic           ir_ld, pc_inc, pc_ld, acc_ld, sel_operand;

    acc_cpu_ctrl #(.OPW(OPW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .zero(zero_q),
        .state(state_q), .ir_ld(ir_ld), .pc_inc(pc_inc), .pc_ld(pc_ld),
        .acc_ld(acc_ld), .sel_operand(sel_operand), .mem_we(mem_we),
        .halted(halted)
    );

    acc_cpu_dpath #(.W(W), .AW(AW)) u_dpath (
        .clk(clk), .rst_n(rst_n), .ir_ld(ir_ld), .pc_inc(pc_inc),
        .pc_ld(pc_ld), .acc_ld(acc_ld), .sel_operand(sel_operand),
        .rdata(mem_rdata), .alu_result(alu_result), .opcode(opcode),
        .acc(acc_q), .zero(zero_q), .addr(mem_addr)
    );

    acc_cpu_alu #(.W(W), .OPW(OPW)) u_alu (
        .op(opcode), .acc(acc_q), .operand(mem_rdata), .result(alu_result)
    );

    assign mem_wdata = acc_q;
endmodule

// File: rtl/acc_cpu_chk.sv
// Module: assertion checker bound to acc_cpu. Observes ports plus the
// sequencer state and datapath registers; drives nothing.
module acc_cpu_chk
    import acc_cpu_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int AW = ADDR_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          halted,
    input state_t        state,
    input logic [W-1:0]  acc,
    input logic          zero
);
    // R8: once halted, stays halted until reset.
    assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R8: no memory write and a still address while halted.
    assert_halt_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);
    assert_halt_addr_still_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && $past(halted)) |-> $stable(mem_addr));

    // R5: a store strobe lasts exactly one cycle.
    assert_store_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R4: accumulator only moves at the end of an execute cycle.
    assert_acc_only_in_exec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_EXEC) |=> $stable(acc));

    // R6: zero flag only moves with LOAD/ADD/SUB execution.
    assert_zero_only_in_exec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_EXEC) |=> $stable(zero));
endmodule

bind acc_cpu acc_cpu_chk #(.W(W), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_addr(mem_addr),
    .halted(halted), .state(state_q), .acc(acc_q), .zero(zero_q)
);

// File: tb/acc_cpu_test.sv
// Bench: scoreboard of expected memory writes per program; a monitor pops
// and compares every write the processor makes.
module acc_cpu_test;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_we;
    logic [15:0] mem_rdata;
    logic        halted;

    logic [15:0] mem [MEM_WORDS];
    logic        ld_en = 1'b0;
    logic [9:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;

    int checks = 0;
    int fails  = 0;

    typedef struct packed { logic [11:0] a; logic [15:0] d; } wr_t;
    wr_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_cpu uut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted)
    );

    // Synchronous single-port memory model with a bench load path.
    always @(posedge clk) begin
        if (ld_en) mem[ld_addr] <= ld_data;
        else if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[9:0]];
    end

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Monitor: compare each memory write against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected write", {4'h0, mem_addr}, 16'hxxxx);
            end else begin
                wr_t e;
                e = exp_q.pop_front();
                check(mem_addr == e.a, "R5 store address", {4'h0, mem_addr}, {4'h0, e.a});
                check(mem_wdata == e.d, "R4/R5 store data", mem_wdata, e.d);
            end
        end
    end

    task automatic poke(input int a, input logic [15:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = a[9:0]; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < MEM_WORDS; i++) poke(i, 16'h0000);
    endtask

    task automatic expect_store(input logic [11:0] a, input logic [15:0] d);
        exp_q.push_back('{a: a, d: d});
    endtask

    // Release reset, check start state (R1), run to halt, check R8 hold.
    task automatic run_program(input string name);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(mem_addr == 12'h000, "R1 address in reset", {4'h0, mem_addr}, 16'h0000);
        check(!halted && !mem_we, "R1 halted/we in reset", {14'h0, halted, mem_we}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_addr == 12'h000, "R1 first fetch at 0", {4'h0, mem_addr}, 16'h0000);
        begin
            int n = 0;
            while (!halted && n < 500) begin @(negedge clk); n++; end
            check(halted, "R8 halted reached", {15'h0, halted}, 16'h0001);
        end
        begin
            logic [11:0] a0 = mem_addr;
            repeat (20) @(negedge clk);
            check(halted && !mem_we && mem_addr == a0, "R8 parked after HALT",
                  {4'h0, mem_addr}, {4'h0, a0});
        end
        check(exp_q.size() == 0, {"R10 all stores seen ", name}, 16'(exp_q.size()), 16'h0000);
        exp_q.delete();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // Program 1: R3 encodings, R4 arithmetic, R9 unused opcode, R10 order.
        clear_mem();
        poke(0, 16'h1100); // LOAD 0x100 -> 5
        poke(1, 16'h2101); // ADD 0x101  -> 12
        poke(2, 16'h7200); // opcode 7: no effect (R9)
        poke(3, 16'h4200); // STORE 0x200 = 12
        poke(4, 16'h3101); // SUB 0x101  -> 5
        poke(5, 16'h4201); // STORE 0x201 = 5
        poke(6, 16'hF000); // HALT
        poke(16'h100, 16'd5);
        poke(16'h101, 16'd7);
        expect_store(12'h200, 16'd12);
        expect_store(12'h201, 16'd5);
        run_program("prog1");

        // Program 2: R6 zero flag and BEQ, R7 JMP, R4 wrap to zero.
        clear_mem();
        poke(0,  16'h1100); // LOAD 3
        poke(1,  16'h3100); // SUB 3 -> 0, Z=1
        poke(2,  16'h4200); // STORE 0 (Z kept)
        poke(3,  16'h6006); // BEQ 6 taken
        poke(4,  16'h42FF); // must be skipped
        poke(5,  16'hF000);
        poke(6,  16'h1101); // LOAD FFFF, Z=0
        poke(7,  16'h6004); // BEQ not taken
        poke(8,  16'h2102); // ADD 1 -> 0 wrap, Z=1
        poke(9,  16'h4201); // STORE 0
        poke(10, 16'h500C); // JMP 12 (R7)
        poke(11, 16'hF000);
        poke(12, 16'h1101); // LOAD FFFF
        poke(13, 16'h4202); // STORE FFFF
        poke(14, 16'hF000);
        poke(16'h100, 16'd3);
        poke(16'h101, 16'hFFFF);
        poke(16'h102, 16'd1);
        expect_store(12'h200, 16'h0000);
        expect_store(12'h201, 16'h0000);
        expect_store(12'h202, 16'hFFFF);
        run_program("prog2");

        // Program 3: R2 self-modifying code through the shared memory.
        clear_mem();
        poke(0, 16'h1100); // LOAD encoded "STORE 0x203"
        poke(1, 16'h4003); // STORE into address 3
        poke(2, 16'h1101); // LOAD 0x55
        poke(3, 16'hF000); // overwritten before fetch
        poke(4, 16'hF000);
        poke(16'h100, 16'h4203);
        poke(16'h101, 16'h0055);
        expect_store(12'h003, 16'h4203);
        expect_store(12'h203, 16'h0055);
        run_program("prog3 R2");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule